// File: doc/BRIEF.md
# Accumulator Arithmetic Instruction Unit

This block carries out one arithmetic-group instruction of a 16-bit, four-accumulator instruction set. The caller presents the instruction word, the current contents of all four accumulators and the carry flag, and raises `issue`. In that same cycle the unit reports whether the following instruction must be skipped. At the next rising clock edge it registers a write-back request: which accumulator to update, the new value and the new carry flag.

The operation runs through a fixed chain. First a carry base is chosen from the carry-control field. Next the selected function is applied to the source and destination operands, and the base is toggled if the function overflowed. The resulting 17-bit carry-and-word may then be rotated or byte-swapped. A skip condition is then evaluated on the final word and carry. A no-load bit suppresses the write-back but keeps the skip. Bit numbering below uses bit 15 as the most significant bit of the instruction port.

Top module: `acc_alu_unit`

## Requirements
- R1: An instruction is accepted only when `issue` is 1 and `instr[15]` is 1. Any other cycle produces `skip`=0 and, at the next edge, `wr_en`=0.
- R2: Operand fields are `instr[14:13]` for the source accumulator and `instr[12:11]` for the destination, which also gives `wr_dest`. Accumulator n is read from port `accN`.
- R3: Carry control `instr[5:4]` sets the carry base: 0 gives `carry_in`, 1 gives 0, 2 gives 1, 3 gives the inverse of `carry_in`.
- R4: Function `instr[10:8]` (S = source, D = destination): 0 gives ~S, 1 gives -S, 2 gives S, 3 gives S+1, 4 gives D+~S, 5 gives D-S, 6 gives D+S, 7 gives S&D, all modulo 2^16.
- R5: The carry base is toggled when function 4, 5 or 6 carries out of bit 15, when function 3 has S=16'hFFFF, or when function 1 has S=0. Functions 0, 2 and 7 never toggle it.
- R6: Shift `instr[7:6]` acts on {carry, word}: 1 rotates it left by one, 2 rotates it right by one, 3 swaps the two bytes of the word and leaves the carry unchanged, and 0 leaves both as they are.
- R7: `skip` = `instr[0]` XOR ((`instr[2]` AND word==0) OR (`instr[1]` AND carry==0)), evaluated on the post-shift word and carry, combinationally in the cycle the instruction is presented.
- R8: When `instr[3]` is 1, no write-back occurs (`wr_en`=0 after the edge), but `skip` is still produced.
- R9: An accepted load instruction sets `wr_en`=1 for exactly the cycle after the edge, with `wr_dest`, `wr_data` and `wr_carry` holding its results. After reset, `wr_en`, `wr_dest`, `wr_data` and `wr_carry` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | Instruction present this cycle |
| instr | input | 16 | Instruction word |
| acc0 | input | 16 | Accumulator 0 contents |
| acc1 | input | 16 | Accumulator 1 contents |
| acc2 | input | 16 | Accumulator 2 contents |
| acc3 | input | 16 | Accumulator 3 contents |
| carry_in | input | 1 | Current carry flag |
| skip | output | 1 | Skip next instruction (same cycle) |
| wr_en | output | 1 | Registered write-back request |
| wr_dest | output | 2 | Accumulator to write |
| wr_data | output | 16 | Value to write |
| wr_carry | output | 1 | New carry flag |

## Verification
The assertions assume that `issue`, `instr` and the operand ports are stable over the whole cycle. They also assume that the registered outputs are examined only on edges that follow an accepted or rejected presentation. The bench meets these assumptions by changing inputs only on the falling edge and holding them through the next rising edge. Both the directed vectors and the random words set `instr[15]` explicitly, so the carry-control, shift and no-load assertions see real accepted instructions. A final directed step clears `instr[15]` to exercise rejection.

// File: rtl/acc_alu_unit.sv
module acc_alu_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [15:0]  instr,
  input  logic [W-1:0] acc0,
  input  logic [W-1:0] acc1,
  input  logic [W-1:0] acc2,
  input  logic [W-1:0] acc3,
  input  logic         carry_in,
  output logic         skip,
  output logic         wr_en,
  output logic [1:0]   wr_dest,
  output logic [W-1:0] wr_data,
  output logic         wr_carry
);
  localparam int H = W / 2;

  logic [1:0] f_src, f_dst, f_sh, f_cy;
  logic [2:0] f_fn, f_sk;
  logic       f_nl, accept;

  assign f_src  = instr[14:13];
  assign f_dst  = instr[12:11];
  assign f_fn   = instr[10:8];
  assign f_sh   = instr[7:6];
  assign f_cy   = instr[5:4];
  assign f_nl   = instr[3];
  assign f_sk   = instr[2:0];
  assign accept = issue & instr[15];

  logic [W-1:0] s_op, d_op, fres, res;
  logic         base, tog, cmid, cfin;
  logic [W:0]   sum;

  always_comb begin
    case (f_src)
      2'd0: s_op = acc0;
      2'd1: s_op = acc1;
      2'd2: s_op = acc2;
      default: s_op = acc3;
    endcase
    case (f_dst)
      2'd0: d_op = acc0;
      2'd1: d_op = acc1;
      2'd2: d_op = acc2;
      default: d_op = acc3;
    endcase
  end

  always_comb begin
    case (f_cy)
      2'd0: base = carry_in;
      2'd1: base = 1'b0;
      2'd2: base = 1'b1;
      default: base = ~carry_in;
    endcase
  end

  always_comb begin
    sum  = '0;
    tog  = 1'b0;
    fres = '0;
    case (f_fn)
      3'd0: fres = ~s_op;
      3'd1: begin sum = {1'b0, ~s_op} + {{W{1'b0}}, 1'b1}; fres = sum[W-1:0]; tog = sum[W]; end
      3'd2: fres = s_op;
      3'd3: begin sum = {1'b0, s_op} + {{W{1'b0}}, 1'b1}; fres = sum[W-1:0]; tog = sum[W]; end
      3'd4: begin sum = {1'b0, ~s_op} + {1'b0, d_op}; fres = sum[W-1:0]; tog = sum[W]; end
      3'd5: begin sum = {1'b0, ~s_op} + {1'b0, d_op} + {{W{1'b0}}, 1'b1}; fres = sum[W-1:0]; tog = sum[W]; end
      3'd6: begin sum = {1'b0, s_op} + {1'b0, d_op}; fres = sum[W-1:0]; tog = sum[W]; end
      default: fres = s_op & d_op;
    endcase
    cmid = base ^ tog;
  end

  always_comb begin
    case (f_sh)
      2'd1: begin cfin = fres[W-1]; res = {fres[W-2:0], cmid}; end
      2'd2: begin cfin = fres[0];   res = {cmid, fres[W-1:1]}; end
      2'd3: begin cfin = cmid;      res = {fres[H-1:0], fres[W-1:H]}; end
      default: begin cfin = cmid;   res = fres; end
    endcase
  end

  assign skip = accept & (f_sk[0] ^ ((f_sk[2] & (res == '0)) | (f_sk[1] & ~cfin)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en    <= 1'b0;
      wr_dest  <= '0;
      wr_data  <= '0;
      wr_carry <= 1'b0;
    end else begin
      wr_en <= accept & ~f_nl;
      if (accept & ~f_nl) begin
        wr_dest  <= f_dst;
        wr_data  <= res;
        wr_carry <= cfin;
      end
    end
  end

  AST_REJECT_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && instr[15]) |-> !skip); // R1
  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && instr[15]) |=> !wr_en); // R1
  AST_DEST_FOLLOWS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr[15] && !instr[3]) |=> (wr_en && wr_dest == $past(instr[12:11]))); // R2
  AST_FORCED_ZERO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr[15] && !instr[3] && instr[5:4] == 2'd1 && instr[7:6] == 2'd3
     && (instr[10:8] == 3'd0 || instr[10:8] == 3'd2 || instr[10:8] == 3'd7)) |=> !wr_carry); // R3
  AST_FORCED_ONE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr[15] && !instr[3] && instr[5:4] == 2'd2 && instr[7:6] == 2'd3
     && (instr[10:8] == 3'd0 || instr[10:8] == 3'd2 || instr[10:8] == 3'd7)) |=> wr_carry); // R5
  AST_NOLOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr[15] && instr[3]) |=> (!wr_en && $stable(wr_data))); // R8
  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(issue && instr[15] && !instr[3])); // R9
endmodule

// File: tb/acc_alu_unit_bench.sv
module acc_alu_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {fn3, sh2, cy2, nl1, sk3, S16, D16, cin1, exp_res16, exp_c1, exp_skip1, exp_wr1}
  localparam logic [62:0] VEC [NV] = '{
    {3'd6,2'd0,2'd0,1'b0,3'b000,16'h0001,16'h0002,1'b0,16'h0003,1'b0,1'b0,1'b1},
    {3'd6,2'd0,2'd0,1'b0,3'b100,16'hFFFF,16'h0001,1'b0,16'h0000,1'b1,1'b1,1'b1},
    {3'd5,2'd0,2'd1,1'b0,3'b000,16'h0003,16'h0005,1'b1,16'h0002,1'b1,1'b0,1'b1},
    {3'd5,2'd0,2'd2,1'b0,3'b010,16'h0005,16'h0003,1'b0,16'hFFFE,1'b1,1'b0,1'b1},
    {3'd1,2'd0,2'd3,1'b0,3'b010,16'h0000,16'h0007,1'b0,16'h0000,1'b0,1'b1,1'b1},
    {3'd1,2'd0,2'd0,1'b0,3'b000,16'h0001,16'h0007,1'b1,16'hFFFF,1'b1,1'b0,1'b1},
    {3'd3,2'd0,2'd0,1'b0,3'b000,16'hFFFF,16'h0000,1'b0,16'h0000,1'b1,1'b0,1'b1},
    {3'd0,2'd0,2'd0,1'b0,3'b000,16'h00FF,16'h1111,1'b1,16'hFF00,1'b1,1'b0,1'b1},
    {3'd2,2'd3,2'd0,1'b0,3'b000,16'h1234,16'h0000,1'b0,16'h3412,1'b0,1'b0,1'b1},
    {3'd2,2'd1,2'd0,1'b0,3'b000,16'h8001,16'h0000,1'b0,16'h0002,1'b1,1'b0,1'b1},
    {3'd2,2'd2,2'd0,1'b0,3'b000,16'h0001,16'h0000,1'b1,16'h8000,1'b1,1'b0,1'b1},
    {3'd7,2'd0,2'd0,1'b1,3'b001,16'hF0F0,16'hFF00,1'b1,16'hF000,1'b1,1'b1,1'b0},
    {3'd4,2'd0,2'd0,1'b0,3'b110,16'h0001,16'h0005,1'b0,16'h0003,1'b1,1'b0,1'b1},
    {3'd6,2'd1,2'd0,1'b0,3'b011,16'h8000,16'h8000,1'b0,16'h0001,1'b0,1'b0,1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, issue = 1'b0, carry_in = 1'b0;
  logic [15:0] instr = '0, acc0 = '0, acc1 = '0, acc2 = '0, acc3 = '0;
  logic skip, wr_en, wr_carry;
  logic [1:0] wr_dest;
  logic [15:0] wr_data;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu_unit u_acc_alu_unit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
    .acc0(acc0), .acc1(acc1), .acc2(acc2), .acc3(acc3), .carry_in(carry_in),
    .skip(skip), .wr_en(wr_en), .wr_dest(wr_dest), .wr_data(wr_data), .wr_carry(wr_carry)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] model(input logic [15:0] ins, input logic [15:0] s,
                                         input logic [15:0] d, input logic cin);
    logic c; logic [15:0] r; logic [31:0] wide; logic nc; logic z;
    if (ins[5:4] == 2'd0) c = cin;
    else if (ins[5:4] == 2'd1) c = 1'b0;
    else if (ins[5:4] == 2'd2) c = 1'b1;
    else c = !cin;
    case (ins[10:8])
      3'd0: r = ~s;
      3'd1: begin r = 16'h0 - s; if (s == 16'h0) c = !c; end
      3'd2: r = s;
      3'd3: begin r = s + 16'h1; if (s == 16'hFFFF) c = !c; end
      3'd4: begin wide = 32'(d) + 32'(16'hFFFF - s); r = wide[15:0]; if (wide > 32'hFFFF) c = !c; end
      3'd5: begin r = d - s; if (d >= s) c = !c; end
      3'd6: begin wide = 32'(d) + 32'(s); r = wide[15:0]; if (wide > 32'hFFFF) c = !c; end
      default: r = s & d;
    endcase
    if (ins[7:6] == 2'd1) begin nc = r[15]; r = (r << 1) | 16'(c); c = nc; end
    else if (ins[7:6] == 2'd2) begin nc = r[0]; r = (r >> 1) | (c ? 16'h8000 : 16'h0); c = nc; end
    else if (ins[7:6] == 2'd3) r = {r[7:0], r[15:8]};
    z = ((ins[2] && r == 16'h0) || (ins[1] && !c));
    return {r, c, z ^ ins[0]};
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [17:0] m;
    logic [15:0] sv, dv;
    repeat (2) @(negedge clk);
    // R9 reset state
    check("R9 reset wr_en", 32'(wr_en), 0);
    check("R9 reset wr_data", 32'(wr_data), 0);
    check("R9 reset wr_carry", 32'(wr_carry), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [62:0] v;
      v = VEC[i];
      instr = {1'b1, 2'd1, 2'd2, v[62:60], v[59:58], v[57:56], v[55], v[54:52]};
      acc0 = 16'hAAAA; acc1 = v[51:36]; acc2 = v[35:20]; acc3 = 16'h5555;
      carry_in = v[19]; issue = 1'b1;
      #1;
      check($sformatf("R7 vec%0d skip", i), 32'(skip), 32'(v[1]));
      @(negedge clk);
      issue = 1'b0;
      check($sformatf("R8 vec%0d wr_en", i), 32'(wr_en), 32'(v[0]));
      if (v[0]) begin
        check($sformatf("R4 R6 vec%0d data", i), 32'(wr_data), 32'(v[18:3]));
        check($sformatf("R3 R5 vec%0d carry", i), 32'(wr_carry), 32'(v[2]));
        check($sformatf("R2 vec%0d dest", i), 32'(wr_dest), 2);
      end
    end
    for (int k = 0; k < 300; k++) begin
      instr = 16'($urandom) | 16'h8000;
      acc0 = 16'($urandom); acc1 = 16'($urandom); acc2 = 16'($urandom); acc3 = 16'($urandom);
      if (k % 5 == 0) acc1 = 16'hFFFF;
      if (k % 7 == 0) acc2 = 16'h0000;
      carry_in = 1'($urandom); issue = 1'b1;
      case (instr[14:13]) 2'd0: sv = acc0; 2'd1: sv = acc1; 2'd2: sv = acc2; default: sv = acc3; endcase
      case (instr[12:11]) 2'd0: dv = acc0; 2'd1: dv = acc1; 2'd2: dv = acc2; default: dv = acc3; endcase
      m = model(instr, sv, dv, carry_in);
      #1;
      check("R7 random skip", 32'(skip), 32'(m[0]));
      @(negedge clk);
      issue = 1'b0;
      check("R8 random wr_en", 32'(wr_en), 32'(!instr[3]));
      if (!instr[3]) begin
        check("R4 random data", 32'(wr_data), 32'(m[17:2]));
        check("R5 random carry", 32'(wr_carry), 32'(m[1]));
        check("R2 random dest", 32'(wr_dest), 32'(instr[12:11]));
      end
    end
    // R1 marker bit clear: skip-forcing word must be ignored
    instr = 16'h0001; issue = 1'b1;
    #1;
    check("R1 ignored skip", 32'(skip), 0);
    @(negedge clk);
    check("R1 ignored wr_en", 32'(wr_en), 0);
    // R1 issue low with valid word
    instr = 16'h8001; issue = 1'b0;
    #1;
    check("R1 idle skip", 32'(skip), 0);
    @(negedge clk);
    check("R9 single-cycle write", 32'(wr_en), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule